// File: doc/BRIEF.md
# Flash Bank Fallback Power Controller

This block sets the power mode of a group of flash banks, three by default. While a bank is being read it stays in active mode. Each accepted access restarts that bank's grace countdown. The countdown starts from a shared programmable grace value. When it expires, the bank drops to the low mode given by its own 2-bit fallback field, which selects either standby or sleep. A later access wakes the bank again. Waking from sleep takes a fixed number of cycles, waking from standby a shorter fixed number, and both counts are parameters.

Each bank has its own access stream with a valid/ready handshake. An access is accepted on a clock edge where both valid and ready are high. Ready is high only while the bank is active. A requester that sees ready low must hold valid high and keep its request unchanged until ready rises. A valid seen while the bank is in a low mode starts the wake sequence. The configuration inputs are plain write strobes and have no handshake.

Top module: `flash_bank_pwr_ctrl`

## Requirements
- R1: After reset every bank is active with ready high, every fallback field holds 3 (active), and the grace value is the parameter GRACE_RST. With no configuration writes, no bank ever leaves active.
- R2: Bank i's fallback field sits at bits [2i+1:2i] of the fallback write data. The field and the mode output bits [2i+1:2i] share one encoding: 0 = sleep, 1 = standby, 3 = active. The mode output never shows 2.
- R3: A fallback field value of 2 is treated as active, so the bank never leaves active mode.
- R4: Let G be the effective grace value. After the last accepted access on clock edge E, the bank stays active through edge E+G and shows its fallback mode from edge E+G+1 on.
- R5: A written grace value of 0 or 1 behaves as 2.
- R6: An access accepted while the countdown runs restarts it from G, so the fall is timed from the newest access.
- R7: Ready is low in standby, in sleep and while waking. The edge that first sees valid in a low mode starts the wake. Ready rises WAKE_SLEEP_CYC edges later when waking from sleep and WAKE_STBY_CYC edges later when waking from standby.
- R8: Accesses to one bank do not change the mode or ready of any other bank.
- R9: While a bank is low or waking, its mode output keeps the low mode it entered. Rewriting its field in that time changes neither the output nor the wake time.
- R10: Suppose a bank's countdown has already expired while its field was active. If its field is then written to a low mode, the bank falls one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_wr_en | input | 1 | Write strobe for all fallback fields |
| fb_wr_data | input | 2*NUM_BANKS | New fallback fields, 2 bits per bank |
| grace_wr_en | input | 1 | Write strobe for the grace value |
| grace_wr_data | input | GRACE_W | New grace value |
| acc_valid | input | NUM_BANKS | Per-bank access request |
| acc_ready | output | NUM_BANKS | Per-bank access accept (bank active) |
| bank_mode | output | 2*NUM_BANKS | Per-bank current power mode |

## Verification
The embedded assertions check several rules on every cycle. An accepted access keeps ready high for at least the two following cycles, which is the clamped minimum grace. Ready never falls on a cycle that carried a request. A bank in a low mode keeps ready low and its mode steady until it is asked to wake. The reserved code never reaches the mode outputs. The exact cycle counts are shown only by the bench's scenarios: the fall at grace plus one, the restart on a new access, the two wake lengths and the one-edge fall after a late field write. The same holds for the rule that a field rewritten during a low period has no effect and for the independence of the banks.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam logic [1:0] PM_SLEEP  = 2'd0;
  localparam logic [1:0] PM_STBY   = 2'd1;
  localparam logic [1:0] PM_RSVD   = 2'd2;
  localparam logic [1:0] PM_ACTIVE = 2'd3;

  typedef enum logic [1:0] {
    BK_ACTIVE = 2'd0,
    BK_LOW    = 2'd1,
    BK_WAKE   = 2'd2
  } bank_st_e;
endpackage

// File: rtl/fbp_cfg.sv
module fbp_cfg
  import fbp_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int GRACE_W   = 8,
  parameter int GRACE_RST = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fb_wr_en,
  input  logic [2*NUM_BANKS-1:0] fb_wr_data,
  input  logic                   grace_wr_en,
  input  logic [GRACE_W-1:0]     grace_wr_data,
  output logic [2*NUM_BANKS-1:0] target_o,
  output logic [GRACE_W-1:0]     grace_eff_o
);
  localparam logic [GRACE_W-1:0] GRACE_MIN = GRACE_W'(2);

  logic [2*NUM_BANKS-1:0] fb_q;
  logic [GRACE_W-1:0]     grace_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_q    <= '1;
      grace_q <= GRACE_W'(GRACE_RST);
    end else begin
      if (fb_wr_en)    fb_q    <= fb_wr_data;
      if (grace_wr_en) grace_q <= grace_wr_data;
    end
  end

  // shared grace value, clamped to a minimum of 2
  always_comb grace_eff_o = (grace_q < GRACE_MIN) ? GRACE_MIN : grace_q;

  // reserved code maps to active
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_map
    always_comb begin
      target_o[2*i +: 2] = (fb_q[2*i +: 2] == PM_RSVD) ? PM_ACTIVE : fb_q[2*i +: 2];
    end
  end
endmodule

// File: rtl/fbp_bank.sv
module fbp_bank
  import fbp_pkg::*;
#(
  parameter int GRACE_W        = 8,
  parameter int WAKE_SLEEP_CYC = 16,
  parameter int WAKE_STBY_CYC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         target_i,
  input  logic [GRACE_W-1:0] grace_i,
  input  logic               acc_valid_i,
  output logic               acc_ready_o,
  output logic [1:0]         mode_o
);
  localparam int WMAX = (WAKE_SLEEP_CYC > WAKE_STBY_CYC) ? WAKE_SLEEP_CYC : WAKE_STBY_CYC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam logic [WW-1:0] SLEEP_LD = WW'(WAKE_SLEEP_CYC - 1);
  localparam logic [WW-1:0] STBY_LD  = WW'(WAKE_STBY_CYC - 1);

  bank_st_e           st;
  logic [GRACE_W-1:0] gcnt;
  logic [WW-1:0]      wcnt;
  logic [1:0]         lo_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= BK_ACTIVE;
      gcnt    <= '0;
      wcnt    <= '0;
      lo_mode <= PM_ACTIVE;
    end else begin
      unique case (st)
        BK_ACTIVE: begin
          if (acc_valid_i) begin
            gcnt <= grace_i;
          end else if (gcnt != '0) begin
            gcnt <= gcnt - 1'b1;
          end else if (target_i != PM_ACTIVE) begin
            st      <= BK_LOW;
            lo_mode <= target_i;
          end
        end
        BK_LOW: begin
          if (acc_valid_i) begin
            st   <= BK_WAKE;
            wcnt <= (lo_mode == PM_SLEEP) ? SLEEP_LD : STBY_LD;
          end
        end
        BK_WAKE: begin
          if (wcnt == '0) begin
            st   <= BK_ACTIVE;
            gcnt <= grace_i;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: st <= BK_ACTIVE;
      endcase
    end
  end

  always_comb begin
    acc_ready_o = (st == BK_ACTIVE);
    mode_o      = (st == BK_ACTIVE) ? PM_ACTIVE : lo_mode;
  end

  // R5
  grace_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_ready_o) |=> ##1 acc_ready_o);

  // R4
  no_fall_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_ready_o) |-> !$past(acc_valid_i));

  // R7
  low_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_LOW) |=> !acc_ready_o);

  // R9
  low_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_LOW && !acc_valid_i) |=> $stable(mode_o));

  // R2
  no_rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != PM_RSVD);
endmodule

// File: rtl/flash_bank_pwr_ctrl.sv
module flash_bank_pwr_ctrl
  import fbp_pkg::*;
#(
  parameter int NUM_BANKS      = 3,
  parameter int GRACE_W        = 8,
  parameter int GRACE_RST      = 8,
  parameter int WAKE_SLEEP_CYC = 16,
  parameter int WAKE_STBY_CYC  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fb_wr_en,
  input  logic [2*NUM_BANKS-1:0] fb_wr_data,
  input  logic                   grace_wr_en,
  input  logic [GRACE_W-1:0]     grace_wr_data,
  input  logic [NUM_BANKS-1:0]   acc_valid,
  output logic [NUM_BANKS-1:0]   acc_ready,
  output logic [2*NUM_BANKS-1:0] bank_mode
);
  logic [2*NUM_BANKS-1:0] target;
  logic [GRACE_W-1:0]     grace_eff;

  fbp_cfg #(
    .NUM_BANKS (NUM_BANKS),
    .GRACE_W   (GRACE_W),
    .GRACE_RST (GRACE_RST)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .fb_wr_en      (fb_wr_en),
    .fb_wr_data    (fb_wr_data),
    .grace_wr_en   (grace_wr_en),
    .grace_wr_data (grace_wr_data),
    .target_o      (target),
    .grace_eff_o   (grace_eff)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    fbp_bank #(
      .GRACE_W        (GRACE_W),
      .WAKE_SLEEP_CYC (WAKE_SLEEP_CYC),
      .WAKE_STBY_CYC  (WAKE_STBY_CYC)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .target_i    (target[2*i +: 2]),
      .grace_i     (grace_eff),
      .acc_valid_i (acc_valid[i]),
      .acc_ready_o (acc_ready[i]),
      .mode_o      (bank_mode[2*i +: 2])
    );
  end
endmodule

// File: tb/flash_bank_pwr_ctrl_tb.sv
module flash_bank_pwr_ctrl_tb;
  localparam int NB = 3;
  localparam int WS = 16;
  localparam int WT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fb_wr_en = 1'b0;
  logic [2*NB-1:0] fb_wr_data = '1;
  logic          grace_wr_en = 1'b0;
  logic [7:0]    grace_wr_data = '0;
  logic [NB-1:0] acc_valid = '0;
  logic [NB-1:0] acc_ready;
  logic [2*NB-1:0] bank_mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  flash_bank_pwr_ctrl #(
    .NUM_BANKS(NB), .GRACE_W(8), .GRACE_RST(8),
    .WAKE_SLEEP_CYC(WS), .WAKE_STBY_CYC(WT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .fb_wr_en(fb_wr_en), .fb_wr_data(fb_wr_data),
    .grace_wr_en(grace_wr_en), .grace_wr_data(grace_wr_data),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .bank_mode(bank_mode)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fb_wr_en = 1'b0; grace_wr_en = 1'b0; acc_valid = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic set_grace(input logic [7:0] g);
    grace_wr_en = 1'b1; grace_wr_data = g;
    tick(1);
    grace_wr_en = 1'b0;
  endtask

  // write fields and access bank b on the same edge E; returns at negedge after E
  task automatic fb_and_access(input logic [2*NB-1:0] fb, input int b);
    fb_wr_en = 1'b1; fb_wr_data = fb; acc_valid[b] = 1'b1;
    tick(1);
    fb_wr_en = 1'b0; acc_valid[b] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(bank_mode, 6'b111111, "R1 reset modes");
    check(acc_ready, 3'b111, "R1 reset ready");
    tick(40);
    check(bank_mode, 6'b111111, "R1 idle stays active");
  endtask

  task automatic t_fall_and_wake_sleep();
    do_reset();
    set_grace(8'd5);
    fb_and_access(6'b111100, 0);
    tick(5);
    check(bank_mode[1:0], 3, "R4 active at E+G");
    check(acc_ready[0], 1, "R4 ready at E+G");
    tick(1);
    check(bank_mode[1:0], 0, "R4 R2 sleep at E+G+1");
    check(acc_ready[0], 0, "R7 ready low in sleep");
    acc_valid[0] = 1'b1;
    tick(WS);
    check(acc_ready[0], 0, "R7 still waking from sleep");
    check(bank_mode[1:0], 0, "R9 mode held while waking");
    tick(1);
    check(acc_ready[0], 1, "R7 sleep wake length");
    check(bank_mode[1:0], 3, "R7 active after wake");
    tick(1);
    acc_valid[0] = 1'b0;
  endtask

  task automatic t_fall_and_wake_stby();
    do_reset();
    set_grace(8'd4);
    fb_and_access(6'b110111, 1);
    tick(4);
    check(bank_mode[3:2], 3, "R4 standby bank active at E+G");
    tick(1);
    check(bank_mode[3:2], 1, "R2 standby code");
    acc_valid[1] = 1'b1;
    tick(WT);
    check(acc_ready[1], 0, "R7 still waking from standby");
    tick(1);
    check(acc_ready[1], 1, "R7 standby wake length");
    tick(1);
    acc_valid[1] = 1'b0;
  endtask

  task automatic t_reload();
    do_reset();
    set_grace(8'd5);
    fb_and_access(6'b111100, 0);
    tick(2);
    acc_valid[0] = 1'b1;
    tick(1);
    acc_valid[0] = 1'b0;
    tick(5);
    check(bank_mode[1:0], 3, "R6 restart postpones fall");
    tick(1);
    check(bank_mode[1:0], 0, "R6 falls G+1 after newest access");
  endtask

  task automatic t_reserved();
    do_reset();
    set_grace(8'd2);
    fb_and_access(6'b111011, 1);
    tick(30);
    check(bank_mode[3:2], 3, "R3 reserved code stays active");
    check(acc_ready[1], 1, "R3 reserved code ready");
  endtask

  task automatic t_small_grace();
    for (int g = 0; g < 2; g++) begin
      do_reset();
      set_grace(8'(g));
      fb_and_access(6'b011111, 2);
      tick(2);
      check(bank_mode[5:4], 3, "R5 clamped grace active at E+2");
      tick(1);
      check(bank_mode[5:4], 1, "R5 clamped grace falls at E+3");
    end
  endtask

  task automatic t_indep();
    do_reset();
    set_grace(8'd3);
    fb_and_access(6'b111100, 0);
    tick(4);
    check(bank_mode[1:0], 0, "R8 bank0 asleep");
    acc_valid[2] = 1'b1;
    tick(1);
    acc_valid[2] = 1'b0;
    tick(2);
    check(bank_mode, 6'b111100, "R8 other banks unaffected");
    check(acc_ready, 3'b110, "R8 ready per bank");
  endtask

  task automatic t_field_change();
    do_reset();
    tick(5);
    fb_wr_en = 1'b1; fb_wr_data = 6'b110111;
    tick(1);
    fb_wr_en = 1'b0;
    check(bank_mode[3:2], 3, "R10 active on write edge");
    tick(1);
    check(bank_mode[3:2], 1, "R10 falls one edge after write");
    fb_wr_en = 1'b1; fb_wr_data = 6'b110011;
    tick(1);
    fb_wr_en = 1'b0;
    tick(3);
    check(bank_mode[3:2], 1, "R9 rewrite keeps low mode");
    acc_valid[1] = 1'b1;
    tick(WT);
    check(acc_ready[1], 0, "R9 wake length unchanged before");
    tick(1);
    check(acc_ready[1], 1, "R9 wake uses entered mode");
    tick(1);
    acc_valid[1] = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fall_and_wake_sleep();
    t_fall_and_wake_stby();
    t_reload();
    t_reserved();
    t_small_grace();
    t_indep();
    t_field_change();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule